// File: doc/BRIEF.md
# Serial EEPROM Read Responder

This block plays the memory side of a three-wire serial EEPROM whose select, clock and data-in lines are bits that software toggles through register writes. The block oversamples those lines with the system clock. It treats a low-to-high change of the serial clock bit, while select is high, as one serial clock event. From those events it collects a start bit, a two-bit command and a six-bit word address. It then returns a 16-bit word on its data-out bit, most significant bit first, one bit per event.

Only the read command (2'b10) is served. The word store is `MEM_WORDS` words deep. Three word addresses, each set by a parameter, return byte pairs of a 48-bit station address presented on an input port. Every other in-range address reads as zero. A command other than read, or an address at or beyond `MEM_WORDS`, raises a sticky error flag and sends the decoder back to waiting for a start bit.

Top module: `eep_read_responder`

## Requirements
- R1: After reset, `dout_o` is 0, `err_o` is 0 and the decoder waits for a start bit.
- R2: The decoder advances only on a cycle where `sel_i` is high, `sclk_i` is high and `sclk_i` was low on the previous cycle. Holding `sclk_i` high for many cycles counts as one event, and clock events while `sel_i` is low have no effect.
- R3: While `sel_i` is low, the decoder returns to waiting for a start bit, so a partly sent command is discarded.
- R4: While the decoder waits for a start bit, a clock event with `din_i` low is ignored. An event with `din_i` high is the start bit.
- R5: After the start bit, two command bits and then six address bits are taken from `din_i`, most significant bit first. The read command is 2'b10.
- R6: The clock event that completes the address loads the word. The next 16 events each put one word bit on `dout_o`, most significant bit first. After the 16th bit the decoder waits for a new start bit, even if `sel_i` stays high.
- R7: Station address byte n is `mac_i[8n+7:8n]`. Word address `WA_B54` (default 7) returns bytes 5:4 (`mac_i[47:32]`). `WA_B32` (default 8) returns bytes 3:2 (`mac_i[31:16]`). `WA_B10` (default 9) returns bytes 1:0 (`mac_i[15:0]`). Any other address below `MEM_WORDS` (default 16) returns 16'h0000.
- R8: A command other than 2'b10 sets `err_o`. The decoder then waits for a start bit, `dout_o` is unchanged, and `err_o` stays set until reset.
- R9: An address at or above `MEM_WORDS` sets `err_o`. The decoder then waits for a start bit and no data is shifted out.
- R10: `dout_o` keeps its last value between clock events and while `sel_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select bit |
| sclk_i | input | 1 | Serial clock bit, sampled by `clk` |
| din_i | input | 1 | Serial data from the host |
| mac_i | input | 48 | Station address, byte n at bits 8n+7:8n |
| dout_o | output | 1 | Serial data to the host |
| err_o | output | 1 | Sticky error flag for a bad command or address |

## Verification
The hardest cases to reach from the ports are the framing ones. These are a serial clock held high across many system cycles, a command dropped halfway through its address, and a second read that starts with select left high right after the 16th data bit. In each case a framing slip still yields a plausible bit stream. The bench therefore drives the serial clock through a task with an adjustable high time, and it cuts select in the middle of an address. It runs back-to-back reads and compares each recovered word with a value computed from the station address. Every in-range word address is also swept with two station address patterns, and the error path is tested at the exact range boundary.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int OP_W   = 2;
    localparam int ADDR_W = 6;
    localparam int WORD_W = 16;
    localparam int MAC_W  = 48;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    localparam logic [OP_W-1:0] OP_READ = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OP   = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } eep_state_t;

    typedef struct packed {
        eep_state_t        st;
        logic [CNT_W-1:0]  cnt;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] shreg;
        logic              dout;
        logic              err;
    } eep_ctx_t;

    // Byte pair idx of the station address: bytes 2*idx+1 (upper) and 2*idx (lower)
    function automatic logic [WORD_W-1:0] mac_pair(input logic [MAC_W-1:0] mac, input int idx);
        return mac[WORD_W*idx +: WORD_W];
    endfunction

endpackage

// File: rtl/eep_sclk_edge.sv
module eep_sclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic sclk_i,
    output logic tick_o
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_i;
    end

    assign tick_o = sel_i & sclk_i & ~sclk_q;
endmodule

// File: rtl/eep_word_map.sv
module eep_word_map
    import eep_pkg::*;
#(
    parameter int MEM_WORDS = 16,
    parameter int WA_B54    = 7,
    parameter int WA_B32    = 8,
    parameter int WA_B10    = 9
) (
    input  logic [MAC_W-1:0]  mac_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] word_o,
    output logic              in_range_o
);
    localparam int NPAIR = MAC_W / WORD_W;
    localparam int PAIR_ADDR [NPAIR] = '{WA_B10, WA_B32, WA_B54};

    logic [WORD_W-1:0] part [NPAIR];

    for (genvar gi = 0; gi < NPAIR; gi++) begin : g_pair
        assign part[gi] = (int'(addr_i) == PAIR_ADDR[gi]) ? mac_pair(mac_i, gi) : '0;
    end

    always_comb begin
        word_o = '0;
        for (int i = 0; i < NPAIR; i++) word_o = word_o | part[i];
    end

    assign in_range_o = int'(addr_i) < MEM_WORDS;
endmodule

// File: rtl/eep_seq.sv
module eep_seq
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              din_i,
    input  logic              tick_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              in_range_i,
    output logic [ADDR_W-1:0] addr_probe_o,
    output eep_state_t        state_o,
    output logic              dout_o,
    output logic              err_o
);
    eep_ctx_t cur, nxt;
    logic [OP_W-1:0] op_shift;

    assign op_shift     = {cur.op[OP_W-2:0], din_i};
    assign addr_probe_o = {cur.addr[ADDR_W-2:0], din_i};

    always_comb begin
        nxt = cur;
        if (!sel_i) begin
            nxt.st  = ST_IDLE;
            nxt.cnt = '0;
        end else if (tick_i) begin
            unique case (cur.st)
                ST_IDLE: begin
                    if (din_i) begin
                        nxt.st  = ST_OP;
                        nxt.cnt = CNT_W'(OP_W);
                        nxt.op  = '0;
                    end
                end
                ST_OP: begin
                    nxt.op  = op_shift;
                    nxt.cnt = cur.cnt - 1'b1;
                    if (cur.cnt == CNT_W'(1)) begin
                        if (op_shift == OP_READ) begin
                            nxt.st   = ST_ADDR;
                            nxt.cnt  = CNT_W'(ADDR_W);
                            nxt.addr = '0;
                        end else begin
                            nxt.st  = ST_IDLE;
                            nxt.err = 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    nxt.addr = addr_probe_o;
                    nxt.cnt  = cur.cnt - 1'b1;
                    if (cur.cnt == CNT_W'(1)) begin
                        if (in_range_i) begin
                            nxt.st    = ST_DATA;
                            nxt.cnt   = CNT_W'(WORD_W);
                            nxt.shreg = word_i;
                        end else begin
                            nxt.st  = ST_IDLE;
                            nxt.err = 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    nxt.dout  = cur.shreg[WORD_W-1];
                    nxt.shreg = {cur.shreg[WORD_W-2:0], 1'b0};
                    nxt.cnt   = cur.cnt - 1'b1;
                    if (cur.cnt == CNT_W'(1)) nxt.st = ST_IDLE;
                end
                default: nxt.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign state_o = cur.st;
    assign dout_o  = cur.dout;
    assign err_o   = cur.err;
endmodule

// File: rtl/eep_read_responder.sv
module eep_read_responder
    import eep_pkg::*;
#(
    parameter int MEM_WORDS = 16,
    parameter int WA_B54    = 7,
    parameter int WA_B32    = 8,
    parameter int WA_B10    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             sclk_i,
    input  logic             din_i,
    input  logic [MAC_W-1:0] mac_i,
    output logic             dout_o,
    output logic             err_o
);
    logic              tick;
    logic [ADDR_W-1:0] addr_probe;
    logic [WORD_W-1:0] word;
    logic              in_range;
    eep_state_t        cur_state;

    eep_sclk_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sel_i),
        .sclk_i (sclk_i),
        .tick_o (tick)
    );

    eep_word_map #(
        .MEM_WORDS (MEM_WORDS),
        .WA_B54    (WA_B54),
        .WA_B32    (WA_B32),
        .WA_B10    (WA_B10)
    ) u_map (
        .mac_i      (mac_i),
        .addr_i     (addr_probe),
        .word_o     (word),
        .in_range_o (in_range)
    );

    eep_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .sel_i        (sel_i),
        .din_i        (din_i),
        .tick_i       (tick),
        .word_i       (word),
        .in_range_i   (in_range),
        .addr_probe_o (addr_probe),
        .state_o      (cur_state),
        .dout_o       (dout_o),
        .err_o        (err_o)
    );
endmodule

// File: rtl/eep_responder_chk.sv
module eep_responder_chk
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sel_i,
    input logic       sclk_i,
    input logic       dout_o,
    input logic       err_o,
    input eep_state_t state_i
);
    logic prev_sclk;

    always_ff @(posedge clk) begin
        if (rst) prev_sclk <= 1'b0;
        else     prev_sclk <= sclk_i;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!dout_o && !err_o && state_i == ST_IDLE)); // R1

    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !(sel_i && sclk_i && !prev_sclk) |=> $stable(dout_o)); // R10

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> state_i == ST_IDLE); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o); // R8

    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> state_i == ST_IDLE); // R9
endmodule

bind eep_read_responder eep_responder_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel_i),
    .sclk_i  (sclk_i),
    .dout_o  (dout_o),
    .err_o   (err_o),
    .state_i (cur_state)
);

// File: tb/sim_eep_read_responder.sv
`timescale 1ns/1ps
module sim_eep_read_responder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [47:0] mac = '0;
    logic        dout;
    logic        err;

    int n_run  = 0;
    int n_fail = 0;
    int hi_len = 3;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    eep_read_responder u0 (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sel),
        .sclk_i (sclk),
        .din_i  (din),
        .mac_i  (mac),
        .dout_o (dout),
        .err_o  (err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        @(negedge clk);
        din  = b;
        sclk = 1'b1;
        repeat (hi_len) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_word(input logic [47:0] m, input int a);
        if (a == 7) return m[47:32];
        if (a == 8) return m[31:16];
        if (a == 9) return m[15:0];
        return 16'h0000;
    endfunction

    task automatic do_read(input int a, input logic [1:0] op, input bit drop_sel,
                           output logic [15:0] w);
        logic [5:0] av;
        av = 6'(a);
        @(negedge clk);
        sel = 1'b1;
        clk_bit(1'b1);
        clk_bit(op[1]);
        clk_bit(op[0]);
        for (int i = 5; i >= 0; i--) clk_bit(av[i]);
        w = '0;
        if (op == 2'b10 && a < 16) begin
            for (int i = 0; i < 16; i++) begin
                clk_bit(1'b0);
                w = {w[14:0], dout};
            end
        end
        if (drop_sel) begin
            @(negedge clk);
            sel = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sel = 1'b0;
        sclk = 1'b0;
        din = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] w;
        logic [15:0] w2;
        logic        d0;

        do_reset();
        check("R1 dout after reset", 32'(dout), 32'd0);
        check("R1 err after reset", 32'(err), 32'd0);

        // R5 R6 R7: sweep every in-range address with two station addresses
        mac = 48'h0A1B2C3D4E5F;
        for (int a = 0; a < 16; a++) begin
            do_read(a, 2'b10, 1'b1, w);
            check("R7 word sweep A", 32'(w), 32'(exp_word(mac, a)));
        end
        mac = 48'hF0E1D2C3B4A5;
        for (int a = 0; a < 16; a++) begin
            do_read(a, 2'b10, 1'b1, w);
            check("R5 word sweep B", 32'(w), 32'(exp_word(mac, a)));
        end
        check("R7 no error on legal reads", 32'(err), 32'd0);

        // R4: idle clock events with din low are ignored
        @(negedge clk);
        sel = 1'b1;
        clk_bit(1'b0);
        clk_bit(1'b0);
        clk_bit(1'b0);
        do_read(7, 2'b10, 1'b1, w);
        check("R4 leading zeros ignored", 32'(w), 32'(exp_word(mac, 7)));

        // R2: events while deselected do nothing; long-high clock is one event
        d0 = dout;
        clk_bit(1'b1);
        clk_bit(1'b1);
        check("R2 deselected clocks leave dout", 32'(dout), 32'(d0));
        hi_len = 40;
        do_read(8, 2'b10, 1'b1, w);
        hi_len = 3;
        check("R2 long high clock", 32'(w), 32'(exp_word(mac, 8)));

        // R3: drop select mid-address, then a clean read
        @(negedge clk);
        sel = 1'b1;
        clk_bit(1'b1);
        clk_bit(1'b1);
        clk_bit(1'b0);
        clk_bit(1'b0);
        clk_bit(1'b1);
        @(negedge clk);
        sel = 1'b0;
        repeat (2) @(negedge clk);
        do_read(9, 2'b10, 1'b1, w);
        check("R3 abort then read", 32'(w), 32'(exp_word(mac, 9)));

        // R6: back-to-back reads with select held high
        do_read(7, 2'b10, 1'b0, w);
        do_read(9, 2'b10, 1'b1, w2);
        check("R6 first of pair", 32'(w), 32'(exp_word(mac, 7)));
        check("R6 second of pair", 32'(w2), 32'(exp_word(mac, 9)));

        // R10: last bit held long after the read
        repeat (20) @(negedge clk);
        check("R10 dout holds last bit", 32'(dout), 32'(exp_word(mac, 9) & 16'h1));

        // R8: bad command
        check("R8 err clear before", 32'(err), 32'd0);
        d0 = dout;
        do_read(7, 2'b11, 1'b1, w);
        check("R8 err set by bad command", 32'(err), 32'd1);
        check("R8 dout unchanged", 32'(dout), 32'(d0));
        do_read(8, 2'b10, 1'b1, w);
        check("R8 read after error", 32'(w), 32'(exp_word(mac, 8)));
        check("R8 err sticky", 32'(err), 32'd1);

        // R9: range boundary
        do_reset();
        do_read(15, 2'b10, 1'b1, w);
        check("R9 last legal address", 32'(err), 32'd0);
        do_read(16, 2'b10, 1'b1, w);
        check("R9 first illegal address", 32'(err), 32'd1);
        check("R9 no data shifted", 32'(dout), 32'd0);
        do_reset();
        do_read(40, 2'b10, 1'b1, w);
        check("R9 far address", 32'(err), 32'd1);
        do_read(9, 2'b10, 1'b1, w);
        check("R9 recovers to idle", 32'(w), 32'(exp_word(mac, 9)));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule